// File: doc/BRIEF.md
# Four-Way Set-Associative Cache Tag Check

This block is the tag-check stage of a 64 KB cache with four ways and 16-byte lines, sitting on a 32-bit byte address. The address is cut into four fields. The tag is bits 31..14, which is 18 bits. The set index is bits 13..4, which gives 1024 sets. The word within the line is bits 3..2, and the byte within the word is bits 1..0.

Each way owns its own tag store. A tag store holds one tag per set, and a separate array holds one valid flag per set. On a lookup, all four ways are read at the set index. Each way then compares its stored tag against the address tag, and all four comparisons run at the same time. The block reports:
- a per-way hit vector,
- a combined hit flag,
- the binary number of the way that hit,
- the data-RAM word address, formed from the set and word fields.

A fill port writes a tag into one chosen way at one set and marks that entry valid. A single-cycle invalidate clears every valid flag. Choosing a victim way and storing the line data are the job of the surrounding cache controller.

Top module: `tlk_tag_lookup`

## Requirements
- R1: One cycle after a lookup, `data_addr` equals bits 13..2 of that lookup address: the set in bits 11..2 and the word in bits 1..0. It holds that value until the next lookup. Reset clears it to zero.
- R2: `res_valid` is high in the cycle after a cycle with `lk_valid` high and not in reset. It is low in every other cycle.
- R3: `way_hit[i]` is high only when way i has a valid entry at the lookup set and that entry's tag equals lookup address bits 31..14.
- R4: `hit` is the OR of `way_hit`. `hit_way` is the binary index of the set bit of `way_hit`. When there is no hit, or when `res_valid` is low, `hit`, `hit_way` and `way_hit` are all zero.
- R5: A fill writes `fill_addr` bits 31..14 into way `fill_way` at set `fill_addr` bits 13..4 and marks that entry valid. The other ways and the other sets keep their contents.
- R6: Reset, or a cycle with `inval_all` high, clears the valid flag of every way in every set. A lookup afterwards misses until a new fill is made.
- R7: A lookup sees the contents as they were before any fill or invalidate issued in the same cycle. Those writes become visible to lookups issued in later cycles.
- R8: When `fill_en` and `inval_all` are both high in one cycle, the invalidate wins and the filled entry stays invalid.
- R9: Address bits 3..0 have no effect on `way_hit`, `hit` or `hit_way`.
- R10: At most one way hits on any lookup, provided that fills never place the same tag in two ways of one set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_addr | input | 32 | Lookup byte address |
| fill_en | input | 1 | Write a tag into one way |
| fill_way | input | 2 | Way selected for the fill |
| fill_addr | input | 32 | Address whose tag and set are written |
| inval_all | input | 1 | Clear all valid flags |
| res_valid | output | 1 | Lookup result present this cycle |
| way_hit | output | 4 | Per-way hit vector |
| hit | output | 1 | Any way hit |
| hit_way | output | 2 | Index of the hitting way |
| data_addr | output | 12 | Data-RAM word address (set and word) |

## Verification
The one-hot check on `way_hit` assumes that the controller never fills a tag into one way while another way of the same set already holds that tag as valid. The stimulus keeps to this rule: before each fill, the bench looks in its own model for a valid copy of the tag in that set. If one exists, the bench redirects the fill to the way that already holds it. The random phase draws tags and sets from small ranges so that hits, refills and same-cycle fill/lookup collisions happen often. It also mixes in invalidates, including some issued together with a fill.

// File: rtl/tlk_pkg.sv
package tlk_pkg;
  localparam int ADDR_W_DEF   = 32;
  localparam int SET_W_DEF    = 10;
  localparam int LINE_OFF_DEF = 4;
  localparam int BYTE_OFF_DEF = 2;
  localparam int WAYS_DEF     = 4;

  function automatic int tag_width(input int addr_w, input int set_w, input int line_off);
    return addr_w - set_w - line_off;
  endfunction
endpackage

// File: rtl/tlk_tag_ram.sv
module tlk_tag_ram #(
  parameter int DEPTH_W = 10,
  parameter int DATA_W  = 18
) (
  input  logic               clk,
  input  logic               we,
  input  logic [DEPTH_W-1:0] waddr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic               re,
  input  logic [DEPTH_W-1:0] raddr,
  output logic [DATA_W-1:0]  rdata
);
  localparam int DEPTH = 1 << DEPTH_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // read-first single-clock RAM: a read at a written address returns the old word
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/tlk_valid_bank.sv
module tlk_valid_bank #(
  parameter int DEPTH_W = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               set_en,
  input  logic [DEPTH_W-1:0] set_idx,
  input  logic               re,
  input  logic [DEPTH_W-1:0] raddr,
  output logic               rdata
);
  localparam int DEPTH = 1 << DEPTH_W;

  logic [DEPTH-1:0] flags;

  // clear has priority over a set in the same cycle
  always_ff @(posedge clk) begin
    if (rst || clr) flags <= '0;
    else if (set_en) flags[set_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= 1'b0;
    else if (re) rdata <= flags[raddr];
  end
endmodule

// File: rtl/tlk_way_match.sv
module tlk_way_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 18
) (
  input  logic                    en,
  input  logic [WAYS*TAG_W-1:0]   stored_tags,
  input  logic [WAYS-1:0]         stored_valid,
  input  logic [TAG_W-1:0]        look_tag,
  output logic [WAYS-1:0]         way_hit,
  output logic                    any_hit,
  output logic [$clog2(WAYS)-1:0] hit_idx
);
  localparam int IDX_W = $clog2(WAYS);

  logic [WAYS-1:0] cmp;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign cmp[w] = stored_valid[w] &&
                    (stored_tags[w*TAG_W +: TAG_W] == look_tag);
  end

  assign way_hit = en ? cmp : '0;
  assign any_hit = |way_hit;

  // lowest index wins; a single hit is expected
  always_comb begin
    hit_idx = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (way_hit[w]) hit_idx = IDX_W'(w);
    end
  end
endmodule

// File: rtl/tlk_tag_lookup.sv
module tlk_tag_lookup
  import tlk_pkg::*;
#(
  parameter int ADDR_W   = ADDR_W_DEF,
  parameter int SET_W    = SET_W_DEF,
  parameter int LINE_OFF = LINE_OFF_DEF,
  parameter int BYTE_OFF = BYTE_OFF_DEF,
  parameter int WAYS     = WAYS_DEF,
  parameter int TAG_W    = tag_width(ADDR_W, SET_W, LINE_OFF),
  parameter int IDX_W    = $clog2(WAYS),
  parameter int DADDR_W  = SET_W + LINE_OFF - BYTE_OFF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               lk_valid,
  input  logic [ADDR_W-1:0]  lk_addr,
  input  logic               fill_en,
  input  logic [IDX_W-1:0]   fill_way,
  input  logic [ADDR_W-1:0]  fill_addr,
  input  logic               inval_all,
  output logic               res_valid,
  output logic [WAYS-1:0]    way_hit,
  output logic               hit,
  output logic [IDX_W-1:0]   hit_way,
  output logic [DADDR_W-1:0] data_addr
);
  localparam int SET_LO = LINE_OFF;
  localparam int TAG_LO = LINE_OFF + SET_W;

  logic [SET_W-1:0] lk_set, fill_set;
  logic [TAG_W-1:0] lk_tag, fill_tag, lk_tag_q;

  assign lk_set   = lk_addr[SET_LO +: SET_W];
  assign lk_tag   = lk_addr[TAG_LO +: TAG_W];
  assign fill_set = fill_addr[SET_LO +: SET_W];
  assign fill_tag = fill_addr[TAG_LO +: TAG_W];

  logic unused_low_bits;
  assign unused_low_bits = ^{lk_addr[BYTE_OFF-1:0], fill_addr[LINE_OFF-1:0]};

  logic [WAYS*TAG_W-1:0] rd_tags;
  logic [WAYS-1:0]       rd_valid;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic fill_here;
    assign fill_here = fill_en && (fill_way == IDX_W'(w));

    tlk_tag_ram #(.DEPTH_W(SET_W), .DATA_W(TAG_W)) u_tags (
      .clk   (clk),
      .we    (fill_here),
      .waddr (fill_set),
      .wdata (fill_tag),
      .re    (lk_valid),
      .raddr (lk_set),
      .rdata (rd_tags[w*TAG_W +: TAG_W])
    );

    tlk_valid_bank #(.DEPTH_W(SET_W)) u_valid (
      .clk     (clk),
      .rst     (rst),
      .clr     (inval_all),
      .set_en  (fill_here),
      .set_idx (fill_set),
      .re      (lk_valid),
      .raddr   (lk_set),
      .rdata   (rd_valid[w])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      lk_tag_q  <= '0;
      data_addr <= '0;
    end else begin
      res_valid <= lk_valid;
      if (lk_valid) begin
        lk_tag_q  <= lk_tag;
        data_addr <= lk_addr[BYTE_OFF +: DADDR_W];
      end
    end
  end

  tlk_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
    .en           (res_valid),
    .stored_tags  (rd_tags),
    .stored_valid (rd_valid),
    .look_tag     (lk_tag_q),
    .way_hit      (way_hit),
    .any_hit      (hit),
    .hit_idx      (hit_way)
  );

  a_r2_result_follows: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> res_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !res_valid);
  a_r1_data_addr: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> data_addr == $past(lk_addr[BYTE_OFF +: DADDR_W]));
  a_r10_single_way: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $onehot0(way_hit));
  a_r4_index_points_at_hit: assert property (@(posedge clk) disable iff (rst)
    hit |-> way_hit[hit_way]);
  a_r4_miss_quiet: assert property (@(posedge clk) disable iff (rst)
    !hit |-> (hit_way == '0) && (way_hit == '0));
  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> !hit);
endmodule

// File: tb/tlk_tag_lookup_test.sv
`timescale 1ns/1ps
module tlk_tag_lookup_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_addr = '0;
  logic        fill_en = 1'b0;
  logic [1:0]  fill_way = '0;
  logic [31:0] fill_addr = '0;
  logic        inval_all = 1'b0;
  logic        res_valid, hit;
  logic [3:0]  way_hit;
  logic [1:0]  hit_way;
  logic [11:0] data_addr;

  always #5 clk = ~clk;

  tlk_tag_lookup uut (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .fill_en(fill_en), .fill_way(fill_way), .fill_addr(fill_addr),
    .inval_all(inval_all), .res_valid(res_valid), .way_hit(way_hit),
    .hit(hit), .hit_way(hit_way), .data_addr(data_addr)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic [17:0] m_tag [4][1024];
  bit          m_val [4][1024];
  logic [11:0] m_daddr = '0;

  function automatic logic [31:0] mk(input int tag, input int set, input int word, input int byt);
    logic [31:0] a;
    a = {tag[17:0], set[9:0], word[1:0], byt[1:0]};
    return a;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // one clock: drive after a falling edge, update model at the rising edge,
  // compare at the next falling edge
  task automatic step(input string req, input bit lv, input logic [31:0] la,
                      input bit fe, input int fw, input logic [31:0] fa, input bit inv);
    bit       e_rv;
    bit [3:0] e_wh;
    int       e_idx;
    lk_valid = lv; lk_addr = la; fill_en = fe; fill_way = fw[1:0];
    fill_addr = fa; inval_all = inv;
    e_rv = 0; e_wh = '0; e_idx = 0;
    if (rst) m_daddr = '0;
    else if (lv) begin
      e_rv = 1;
      m_daddr = la[13:2];
      for (int w = 0; w < 4; w++)
        if (m_val[w][la[13:4]] && m_tag[w][la[13:4]] == la[31:14]) begin
          e_wh[w] = 1'b1; e_idx = w;
        end
    end
    @(posedge clk);
    if (fe) m_tag[fw][fa[13:4]] = fa[31:14];
    if (rst || inv) begin
      for (int w = 0; w < 4; w++)
        for (int s = 0; s < 1024; s++) m_val[w][s] = 0;
    end else if (fe) m_val[fw][fa[13:4]] = 1;
    @(negedge clk);
    chk({req, "/R2"}, "res_valid", res_valid, e_rv);
    chk({req, "/R3"}, "way_hit", way_hit, e_wh);
    chk({req, "/R4"}, "hit", hit, |e_wh);
    chk({req, "/R4"}, "hit_way", hit_way, e_idx);
    chk({req, "/R1"}, "data_addr", data_addr, m_daddr);
  endtask

  task automatic look(input string req, input logic [31:0] a);
    step(req, 1, a, 0, 0, '0, 0);
  endtask

  task automatic fill(input string req, input int w, input logic [31:0] a);
    step(req, 0, '0, 1, w, a, 0);
  endtask

  // keep tags unique per set: reuse the way that already holds the tag
  function automatic int safe_way(input int w, input logic [31:0] a);
    for (int k = 0; k < 4; k++)
      if (m_val[k][a[13:4]] && m_tag[k][a[13:4]] == a[31:14]) return k;
    return w;
  endfunction

  initial begin
    for (int w = 0; w < 4; w++)
      for (int s = 0; s < 1024; s++) begin m_val[w][s] = 0; m_tag[w][s] = '0; end
    @(negedge clk);
    rst = 1;
    repeat (3) step("R6", 1, mk(5, 5, 1, 1), 0, 0, '0, 0);
    rst = 0;
    // reset state seen at the ports
    step("R6", 0, '0, 0, 0, '0, 0);
    look("R6", mk(5, 5, 1, 1));

    // fills into different ways and sets, then lookups
    fill("R5", 0, mk('h12345, 10, 0, 0));
    fill("R5", 1, mk('h00001, 10, 0, 0));
    fill("R5", 2, mk('h3FFFF, 10, 0, 0));
    fill("R5", 3, mk('h2AAAA, 10, 0, 0));
    fill("R5", 2, mk('h12345, 1023, 0, 0));
    fill("R5", 1, mk('h00000, 0, 0, 0));
    look("R3", mk('h12345, 10, 0, 0));
    look("R3", mk('h00001, 10, 3, 2));
    look("R3", mk('h3FFFF, 10, 1, 0));
    look("R3", mk('h2AAAA, 10, 2, 3));
    look("R5", mk('h12345, 1023, 0, 0));
    look("R5", mk('h00000, 0, 0, 0));
    look("R5", mk('h12345, 11, 0, 0));
    // byte and word bits ignored for the hit
    for (int k = 0; k < 16; k++) look("R9", mk('h12345, 10, k / 4, k % 4));
    // single-bit tag difference misses
    look("R3", mk('h12344, 10, 0, 0));
    look("R3", mk('h02345, 10, 0, 0));
    // refill of a way replaces its tag
    fill("R5", 0, mk('h11111, 10, 0, 0));
    look("R5", mk('h12345, 10, 0, 0));
    look("R5", mk('h11111, 10, 0, 0));
    // same-cycle fill and lookup: old contents first
    step("R7", 1, mk('h0BEEF, 20, 1, 1), 1, 3, mk('h0BEEF, 20, 0, 0), 0);
    look("R7", mk('h0BEEF, 20, 1, 1));
    // same-cycle invalidate and lookup: still hits, then misses
    step("R7", 1, mk('h0BEEF, 20, 0, 0), 0, 0, '0, 1);
    look("R6", mk('h0BEEF, 20, 0, 0));
    look("R6", mk('h2AAAA, 10, 0, 0));
    // invalidate beats a fill in the same cycle
    step("R8", 0, '0, 1, 2, mk('h00777, 33, 0, 0), 1);
    look("R8", mk('h00777, 33, 0, 0));
    fill("R8", 2, mk('h00777, 33, 0, 0));
    look("R8", mk('h00777, 33, 0, 0));
    // mid-run reset clears everything
    rst = 1; step("R6", 0, '0, 0, 0, '0, 0); rst = 0;
    look("R6", mk('h00777, 33, 0, 0));

    // random mix on a narrow tag/set space
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] la, fa;
      bit lv, fe, inv;
      int fw;
      la = mk('h15000 + $urandom_range(0, 5), $urandom_range(0, 7),
              $urandom_range(0, 3), $urandom_range(0, 3));
      fa = mk('h15000 + $urandom_range(0, 5), $urandom_range(0, 7), 0, 0);
      lv = $urandom_range(0, 3) != 0;
      fe = $urandom_range(0, 2) == 0;
      inv = $urandom_range(0, 199) == 0;
      fw = safe_way($urandom_range(0, 3), fa);
      step("R10", lv, la, fe, fw, fa, inv);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule